// File: doc/BRIEF.md
# Label and Source/Destination Word Filter with Parallel Output Latch

This block sits behind a serial word receiver. The receiver hands over each complete 32-bit word with a one-cycle valid strobe. It also gives a one-cycle pulse when the first bit of a possible new word is seen. The filter compares the word's label field with a reference value under a per-bit mask. It can also compare the two source/destination bits with two reference inputs. A word that meets every enabled criterion is copied into a 32-bit parallel output latch. The latch holds that value until another accepted word replaces it, so the outputs can drive downstream logic directly.

The handshake output `update_o` tells downstream logic when the latch contents are fresh. It rises one clock after the latch loads. It falls on the clock edge that follows the start-of-word pulse.

A parameter selects one of two output variants. The true variant keeps its output-enable low from reset until the first accepted word is latched. The complemented variant drives the inverted word, with the enable always high, so every output bit reads 1 after reset.

Top module: `arinc_label_latch`

## Requirements
- R1: For every label bit n (0..7), a set `lbl_mask_i[n]` requires the received label bit n to equal `lbl_ref_i[n]`, and a cleared mask bit ignores label bit n. With mask 0xFC and reference 0x80, labels 0x80 to 0x83 are accepted and 0x84 and 0x00 are rejected.
- R2: When `lbl_mask_i` is 0x00, every label passes the label criterion.
- R3: The label is bit-reversed with respect to arrival. `word_i[0]` is the first bit received and is label bit 7. `word_i[7]` is label bit 0. In general, label bit n is `word_i[7-n]`.
- R4: When `sd_en_i` is 1, `word_i[8]` must equal `sd_ref_i[0]` and `word_i[9]` must equal `sd_ref_i[1]`. When `sd_en_i` is 0, these two bits are not checked.
- R5: A word is latched only when `word_vld_i` is high and both the label criterion and the source/destination criterion pass. A rejected word leaves `data_o`, `data_oe_o` and `update_o` unchanged, apart from the drop already caused by `sow_i`.
- R6: An accepted word appears on `data_o` at the clock edge that samples `word_vld_i`. `update_o` rises on the following edge. If `update_o` is already high and `sow_i` is low, `update_o` stays high.
- R7: `update_o` is 0 after every clock edge that samples `sow_i` high, and `data_o` is not changed by `sow_i`. If a word is accepted in the same cycle as `sow_i`, `update_o` is 0 after that edge and rises on the next edge.
- R8: After reset, `update_o` is 0. In the true variant, `data_oe_o` is 0 until the first accepted word and 1 from then on.
- R9: The complemented variant (`INVERT_OUT`=1) drives `~` of the latched word on `data_o` and holds `data_oe_o` at 1, so `data_o` is all ones after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| sow_i | input | 1 | Start-of-word pulse from the receiver |
| word_vld_i | input | 1 | One-cycle strobe: `word_i` holds a complete word |
| word_i | input | 32 | Received word, bit 0 received first |
| lbl_ref_i | input | 8 | Label reference value |
| lbl_mask_i | input | 8 | Per-bit label compare enable |
| sd_en_i | input | 1 | Enables the source/destination compare |
| sd_ref_i | input | 2 | Source/destination reference bits |
| data_o | output | 32 | Latched word (inverted in the complemented variant) |
| data_oe_o | output | 1 | Output enable for the parallel data |
| update_o | output | 1 | Fresh-data handshake |

## Verification
A wrong match decision shows on `data_o` at the very edge that samples the strobe. Either the word was dropped, or it overwrote a held value that should have stayed. A mistake in the handshake state shows on `update_o` within one or two edges of a strobe or a start-of-word pulse. This includes a missing rise, a rise one clock early, or a stuck high after `sow_i`. A wrong enable flag shows on `data_oe_o` right after reset or after the first accepted word. The bench runs a behavioural model next to two instances, one per variant, and compares every output on every cycle. A fault therefore shows up within one cycle of the event that exposes it.

// File: rtl/arinc_filt_pkg.sv
package arinc_filt_pkg;

   localparam int unsigned ALF_LBL_W = 8;
   localparam int unsigned ALF_SD_W  = 2;

   typedef enum logic [1:0] {
      UPD_LOW  = 2'd0,
      UPD_ARM  = 2'd1,
      UPD_HIGH = 2'd2
   } upd_state_e;

endpackage

// File: rtl/alf_label_cmp.sv
module alf_label_cmp #(
   parameter int unsigned LBL_W = 8
) (
   input  logic [LBL_W-1:0] rx_bits_i,
   input  logic [LBL_W-1:0] ref_i,
   input  logic [LBL_W-1:0] mask_i,
   output logic             hit_o
);
   logic [LBL_W-1:0] bit_ok;

   for (genvar n = 0; n < LBL_W; n++) begin : g_bit
      localparam int unsigned RXPOS = LBL_W - 1 - n;
      assign bit_ok[n] = ~mask_i[n] | (rx_bits_i[RXPOS] == ref_i[n]);
   end

   assign hit_o = &bit_ok;
endmodule

// File: rtl/alf_sd_cmp.sv
module alf_sd_cmp #(
   parameter int unsigned SD_W = 2
) (
   input  logic            en_i,
   input  logic [SD_W-1:0] rx_bits_i,
   input  logic [SD_W-1:0] ref_i,
   output logic            hit_o
);
   assign hit_o = ~en_i | (rx_bits_i == ref_i);
endmodule

// File: rtl/alf_out_latch.sv
module alf_out_latch #(
   parameter int unsigned W          = 32,
   parameter bit          INVERT_OUT = 1'b0
) (
   input  logic         clk_i,
   input  logic         rst_ni,
   input  logic         load_i,
   input  logic [W-1:0] d_i,
   output logic [W-1:0] data_o,
   output logic         data_oe_o
);
   logic [W-1:0] hold_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)     hold_q <= '0;
      else if (load_i) hold_q <= d_i;
   end

   if (INVERT_OUT) begin : g_inv
      assign data_o    = ~hold_q;
      assign data_oe_o = 1'b1;
   end else begin : g_true
      logic seen_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
         if (!rst_ni)     seen_q <= 1'b0;
         else if (load_i) seen_q <= 1'b1;
      end
      assign data_o    = hold_q;
      assign data_oe_o = seen_q;

      AST_OE_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
         !$fell(data_oe_o)); // R8
      AST_OE_RISES_ON_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
         $rose(data_oe_o) |-> $past(load_i)); // R8
   end
endmodule

// File: rtl/alf_update_ctl.sv
module alf_update_ctl
   import arinc_filt_pkg::*;
(
   input  logic clk_i,
   input  logic rst_ni,
   input  logic sow_i,
   input  logic load_i,
   output logic update_o
);
   upd_state_e st_q, st_d;

   always_comb begin
      st_d = st_q;
      if (load_i)
         st_d = (st_q == UPD_HIGH && !sow_i) ? UPD_HIGH : UPD_ARM;
      else if (sow_i)
         st_d = UPD_LOW;
      else if (st_q == UPD_ARM)
         st_d = UPD_HIGH;
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) st_q <= UPD_LOW;
      else         st_q <= st_d;
   end

   assign update_o = (st_q == UPD_HIGH);

   AST_ARM_RESOLVES: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (st_q == UPD_ARM && !load_i && !sow_i) |=> update_o); // R6
endmodule

// File: rtl/arinc_label_latch.sv
module arinc_label_latch
   import arinc_filt_pkg::*;
#(
   parameter int unsigned WORD_W     = 32,
   parameter int unsigned LABEL_W    = ALF_LBL_W,
   parameter int unsigned SDB_W      = ALF_SD_W,
   parameter bit          INVERT_OUT = 1'b0
) (
   input  logic                clk_i,
   input  logic                rst_ni,
   input  logic                sow_i,
   input  logic                word_vld_i,
   input  logic [WORD_W-1:0]   word_i,
   input  logic [LABEL_W-1:0]  lbl_ref_i,
   input  logic [LABEL_W-1:0]  lbl_mask_i,
   input  logic                sd_en_i,
   input  logic [SDB_W-1:0]    sd_ref_i,
   output logic [WORD_W-1:0]   data_o,
   output logic                data_oe_o,
   output logic                update_o
);
   localparam int unsigned SD_LO = LABEL_W;
   localparam int unsigned SD_HI = LABEL_W + SDB_W - 1;

   if (WORD_W < LABEL_W + SDB_W) begin : g_bad_width
      $error("arinc_label_latch: WORD_W too small for label and SD fields");
   end
   if (LABEL_W == 0 || SDB_W == 0) begin : g_bad_field
      $error("arinc_label_latch: field widths must be non-zero");
   end

   logic lbl_hit, sd_hit, load;

   alf_label_cmp #(.LBL_W(LABEL_W)) u_lbl (
      .rx_bits_i (word_i[LABEL_W-1:0]),
      .ref_i     (lbl_ref_i),
      .mask_i    (lbl_mask_i),
      .hit_o     (lbl_hit)
   );

   alf_sd_cmp #(.SD_W(SDB_W)) u_sd (
      .en_i      (sd_en_i),
      .rx_bits_i (word_i[SD_HI:SD_LO]),
      .ref_i     (sd_ref_i),
      .hit_o     (sd_hit)
   );

   assign load = word_vld_i & lbl_hit & sd_hit;

   alf_out_latch #(.W(WORD_W), .INVERT_OUT(INVERT_OUT)) u_lat (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .load_i    (load),
      .d_i       (word_i),
      .data_o    (data_o),
      .data_oe_o (data_oe_o)
   );

   alf_update_ctl u_upd (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .sow_i    (sow_i),
      .load_i   (load),
      .update_o (update_o)
   );

   AST_ZERO_MASK_PASSES: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (lbl_mask_i == '0) |-> lbl_hit); // R2
   AST_SD_OFF_PASSES: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !sd_en_i |-> sd_hit); // R4
   AST_CHANGE_NEEDS_MATCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (data_o != $past(data_o)) |-> $past(word_vld_i && lbl_hit && sd_hit)); // R5
   AST_SOW_DROPS_UPDATE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      sow_i |=> !update_o); // R7
   AST_RISE_AFTER_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(update_o) |-> $past(load, 2)); // R6
endmodule

// File: tb/tb_arinc_label_latch.sv
`timescale 1ns/1ps
module tb_arinc_label_latch;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        sow = 1'b0, vld = 1'b0, sd_en = 1'b0;
   logic [31:0] word = '0;
   logic [7:0]  lref = '0, lmask = '0;
   logic [1:0]  sdref = '0;
   logic [31:0] d_t, d_c;
   logic        oe_t, oe_c, upd_t, upd_c;

   int checks = 0, fails = 0;
   bit done = 1'b0;
   string tag = "R8";

   always #2.5 clk = ~clk;

   arinc_label_latch #(.INVERT_OUT(1'b0)) dut (
      .clk_i(clk), .rst_ni(rst_n), .sow_i(sow), .word_vld_i(vld), .word_i(word),
      .lbl_ref_i(lref), .lbl_mask_i(lmask), .sd_en_i(sd_en), .sd_ref_i(sdref),
      .data_o(d_t), .data_oe_o(oe_t), .update_o(upd_t));
   arinc_label_latch #(.INVERT_OUT(1'b1)) dut_c (
      .clk_i(clk), .rst_ni(rst_n), .sow_i(sow), .word_vld_i(vld), .word_i(word),
      .lbl_ref_i(lref), .lbl_mask_i(lmask), .sd_en_i(sd_en), .sd_ref_i(sdref),
      .data_o(d_c), .data_oe_o(oe_c), .update_o(upd_c));

   // behavioural reference
   logic [31:0] m_lat;
   bit m_oe, m_upd, m_pend;

   function automatic bit accepts(logic [31:0] w);
      for (int n = 0; n < 8; n++)
         if (lmask[n] && (w[7-n] !== lref[n])) return 0;
      if (sd_en && (w[8] !== sdref[0] || w[9] !== sdref[1])) return 0;
      return 1;
   endfunction

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_lat = '0; m_oe = 0; m_upd = 0; m_pend = 0;
      end else begin
         bit acc;
         acc = vld && accepts(word);
         if (acc) begin
            m_lat = word; m_oe = 1;
            if (m_upd && !sow) m_pend = 0;
            else begin m_upd = 0; m_pend = 1; end
         end else if (sow) begin
            m_upd = 0; m_pend = 0;
         end else if (m_pend) begin
            m_upd = 1; m_pend = 0;
         end
      end
   end

   task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
      end
   endtask

   always @(negedge clk) if (rst_n && !done) begin
      chk(tag, {d_t, 29'd0, oe_t, upd_t, 1'b0}, {m_lat, 29'd0, m_oe, m_upd, 1'b0});
      chk("R9", {d_c, 30'd0, oe_c, upd_c}, {~m_lat, 30'd0, 1'b1, m_upd});
   end

   function automatic logic [31:0] mk(logic [7:0] lbl, logic [1:0] sd, logic [21:0] hi);
      logic [31:0] w;
      w = {hi, sd, 8'h00};
      for (int n = 0; n < 8; n++) w[7-n] = lbl[n];
      return w;
   endfunction

   task automatic send(input logic [31:0] w, input bit exp_acc, input string req,
                       input bit with_sow = 1'b1);
      logic [31:0] prev_d;
      logic prev_u;
      tag = req;
      prev_d = d_t;
      prev_u = upd_t;
      if (with_sow) begin
         sow = 1'b1; @(negedge clk); sow = 1'b0;
         chk("R7", {63'd0, upd_t}, 64'd0);
         chk("R7", {32'd0, d_t}, {32'd0, prev_d});
         repeat (2) @(negedge clk);
      end
      word = w; vld = 1'b1;
      @(negedge clk);
      vld = 1'b0;
      chk(req, {32'd0, d_t}, {32'd0, exp_acc ? w : prev_d});
      chk("R6", {63'd0, upd_t}, {63'd0, with_sow ? 1'b0 : prev_u});
      @(negedge clk);
      chk(exp_acc ? "R6" : "R5", {63'd0, upd_t},
          {63'd0, exp_acc ? 1'b1 : (with_sow ? 1'b0 : prev_u)});
      repeat (2) @(negedge clk);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      chk("R8", {62'd0, oe_t, upd_t}, 64'd0);
      chk("R9", {31'd0, d_c, oe_c}, {31'd0, 32'hFFFF_FFFF, 1'b1});
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      chk("R8", {63'd0, oe_t}, 64'd0);

      // R2: mask zero, any label
      lmask = 8'h00; lref = 8'h5A;
      for (int i = 0; i < 6; i++)
         send(mk(8'($urandom), 2'($urandom), 22'($urandom)), 1'b1, "R2");
      chk("R8", {63'd0, oe_t}, 64'd1);

      // R3: bit reversal with an exact label
      lmask = 8'hFF; lref = 8'h80;
      send(32'h0000_0001, 1'b1, "R3");
      send(32'h0000_0080, 1'b0, "R3");
      send(mk(8'h80, 2'b11, 22'h2A_AAAA), 1'b1, "R3");

      // R1: masked group of labels
      lmask = 8'hFC; lref = 8'h80;
      for (int l = 8'h7E; l <= 8'h85; l++)
         send(mk(8'(l), 2'b01, 22'(l * 977)), (l >= 8'h80 && l <= 8'h83), "R1");
      send(mk(8'h00, 2'b00, 22'h1), 1'b0, "R1");
      lmask = 8'h01; lref = 8'h01;
      send(mk(8'hFE, 2'b00, 22'h7), 1'b0, "R1");
      send(mk(8'h03, 2'b00, 22'h9), 1'b1, "R1");

      // R4: source/destination compare
      lmask = 8'h00; sd_en = 1'b1;
      for (int r = 0; r < 4; r++) begin
         sdref = 2'(r);
         for (int s = 0; s < 4; s++)
            send(mk(8'(r * 16 + s), 2'(s), 22'(r * 5 + s + 100)), (r == s), "R4");
      end
      sd_en = 1'b0; sdref = 2'b10;
      send(mk(8'h11, 2'b01, 22'h3), 1'b1, "R4");

      // R5: label pass but SD fail, and label fail but SD pass
      sd_en = 1'b1; sdref = 2'b11; lmask = 8'hFF; lref = 8'h42;
      send(mk(8'h42, 2'b10, 22'h4), 1'b0, "R5");
      send(mk(8'h43, 2'b11, 22'h5), 1'b0, "R5");
      send(mk(8'h42, 2'b11, 22'h6), 1'b1, "R5");
      sd_en = 1'b0; lmask = 8'h00;

      // R6: accept while update already high, no start pulse
      send(mk(8'h21, 2'b00, 22'h10), 1'b1, "R6", 1'b0);
      send(mk(8'h22, 2'b00, 22'h11), 1'b1, "R6", 1'b0);
      lmask = 8'hFF; lref = 8'h00;
      send(mk(8'h22, 2'b00, 22'h12), 1'b0, "R5", 1'b0);
      lmask = 8'h00;

      // R7: start pulse and accepted word in the same cycle
      tag = "R7";
      word = mk(8'h77, 2'b01, 22'h33); vld = 1'b1; sow = 1'b1;
      @(negedge clk);
      vld = 1'b0; sow = 1'b0;
      chk("R7", {31'd0, d_t, upd_t}, {31'd0, mk(8'h77, 2'b01, 22'h33), 1'b0});
      @(negedge clk);
      chk("R7", {63'd0, upd_t}, 64'd1);
      // start pulse alone: drop, data held
      sow = 1'b1; @(negedge clk); sow = 1'b0;
      chk("R7", {31'd0, d_t, upd_t}, {31'd0, mk(8'h77, 2'b01, 22'h33), 1'b0});
      repeat (4) @(negedge clk);
      chk("R7", {63'd0, upd_t}, 64'd0);

      // reset again mid-run
      tag = "R8";
      rst_n = 1'b0; @(negedge clk);
      chk("R8", {30'd0, d_t, oe_t, upd_t}, 64'd0);
      chk("R9", {32'd0, d_c}, {32'd0, 32'hFFFF_FFFF});
      rst_n = 1'b1; repeat (2) @(negedge clk);
      send(mk(8'h01, 2'b00, 22'h1), 1'b1, "R8");
      chk("R8", {63'd0, oe_t}, 64'd1);

      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         checks++; fails++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end
endmodule